// File: doc/BRIEF.md
# Sector-Indexed Linear Track Fitter

This block turns the hit coordinates of one track candidate into five helix parameters and a fit-quality figure. Every output row is an affine function of the coordinate vector: a signed weighted sum of the coordinates plus a row offset. The weights and offsets come from a constant table that is indexed by the candidate's sector number, so each detector region gets its own linearisation. The first rows give the helix parameters. The remaining rows give residual components, and the fitter squares and adds them into a chi-square value.

Constant rows are loaded through a write port, one full output row per write. Candidates then stream in at one per clock. Each candidate comes out a fixed number of cycles later with its parameters, its chi-square and an accept flag. The accept flag compares the chi-square against a threshold level input.

Top module: `lfit_top`

## Requirements
- R1: While reset is held, and for the first four clocks after it is released, `out_valid` stays low, even if `in_valid` is high during reset. `out_chi2` and `out_accept` read zero after reset.
- R2: `out_valid` follows `in_valid` with a latency of exactly 4 clocks. A candidate can enter on every clock, back to back or with gaps, and results leave in entry order.
- R3: Parameter k (k = 0..NPARAM-1) sits at `out_params[k*ACCW +: ACCW]`. It equals sum over j of a[s][k][j]*x[j] + b[s][k], where x[j] = `in_coords[j*XW +: XW]` and s is `in_sector`. The result is signed, at full precision.
- R4: `out_chi2` is the unsigned sum of the squares of rows NPARAM..NCOORD-1. Each of these rows is computed with the same affine rule as R3.
- R5: The constants used for a fit are those of the sector presented with that candidate. The same coordinates under two sectors give each sector's own result.
- R6: `out_accept` is 1 when `out_chi2` is less than or equal to `chi_limit`, and 0 otherwise. The comparison uses the `chi_limit` value present one clock before the result appears, and equality accepts.
- R7: A write with `cfg_we` high stores `cfg_data` as row `cfg_row` of sector `cfg_sector`. Row numbers 0..NPARAM-1 are the parameter rows and the rest are residual rows. Coefficient j sits at `cfg_data[j*CW +: CW]` and the offset sits at `cfg_data[NCOORD*CW +: CW]`. No other sector and no other row changes.
- R8: In a clock where `out_valid` is low, `out_params`, `out_chi2` and `out_accept` hold their previous values, whatever the inputs are.
- R9: Full-scale negative coordinates, coefficients and offsets give exact results with no wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Constant row write strobe |
| cfg_sector | input | SW | Sector number of the written row |
| cfg_row | input | RIW | Output row index of the written row |
| cfg_data | input | (NCOORD+1)*CW | Packed coefficients and offset |
| chi_limit | input | CHIW | Accept threshold for chi-square |
| in_valid | input | 1 | Candidate present |
| in_sector | input | SW | Candidate sector number |
| in_coords | input | NCOORD*XW | Packed signed hit coordinates |
| out_valid | output | 1 | Result present |
| out_params | output | NPARAM*ACCW | Packed signed helix parameters |
| out_chi2 | output | CHIW | Sum of squared residual rows |
| out_accept | output | 1 | Chi-square at or below threshold |

## Verification
The table contains several coordinate patterns: a rising ramp, alternating signs, a single nonzero coordinate, and all coordinates at full-scale negative.

- The ramp and the alternating pattern expose errors in coordinate or coefficient ordering and in sign extension.
- The single nonzero coordinate isolates one coefficient column plus the offsets.
- The full-scale case exposes truncation of products, sums or squares.

Two candidates share coordinates but differ in sector, which separates the sector lookup from the arithmetic. A rewrite of one sector followed by fits in that sector and its neighbour shows whether writes leak into other sectors. Back-to-back and gapped streams check ordering and latency. Single fits with the threshold set to exactly the chi-square, and to one less, pin down the inclusive comparison.

// File: rtl/lfit_pkg.sv
`timescale 1ns/1ps
package lfit_pkg;
  localparam int unsigned DEF_NCOORD = 14;
  localparam int unsigned DEF_NPARAM = 5;
  localparam int unsigned DEF_NSECT  = 16;
  localparam int unsigned DEF_XW     = 16;
  localparam int unsigned DEF_CW     = 16;
  localparam int unsigned PIPE_LAT   = 4;

  // Width that holds n products of xw*cw bits plus one offset without wrap.
  function automatic int unsigned acc_width(int unsigned xw, int unsigned cw, int unsigned n);
    return xw + cw + $clog2(n + 1);
  endfunction

  // Width that holds the sum of nchi squares of accw-bit signed values.
  function automatic int unsigned chi_width(int unsigned accw, int unsigned nchi);
    return 2 * accw + $clog2(nchi + 1);
  endfunction
endpackage

// File: rtl/lfit_row_ram.sv
`timescale 1ns/1ps
// One output row of constants for every sector; synchronous read.
module lfit_row_ram #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/lfit_mac_row.sv
`timescale 1ns/1ps
// Two pipeline stages: registered products, then registered sum plus offset.
module lfit_mac_row #(
  parameter int NCOORD = 14,
  parameter int XW     = 16,
  parameter int CW     = 16,
  parameter int ACCW   = 36
) (
  input  logic                       clk,
  input  logic [(NCOORD+1)*CW-1:0]   row,
  input  logic [NCOORD*XW-1:0]       x,
  output logic signed [ACCW-1:0]     acc
);
  localparam int PW = XW + CW;

  logic signed [PW-1:0]   prod [NCOORD];
  logic signed [CW-1:0]   off_q;
  logic signed [ACCW-1:0] sum_c;

  always_ff @(posedge clk) begin
    for (int j = 0; j < NCOORD; j++) begin
      prod[j] <= signed'(row[j*CW +: CW]) * signed'(x[j*XW +: XW]);
    end
    off_q <= signed'(row[NCOORD*CW +: CW]);
  end

  always_comb begin
    sum_c = ACCW'(off_q);
    for (int j = 0; j < NCOORD; j++) begin
      sum_c = sum_c + ACCW'(prod[j]);
    end
  end

  always_ff @(posedge clk) acc <= sum_c;
endmodule

// File: rtl/lfit_chi_sum.sv
`timescale 1ns/1ps
// Combinational sum of squares of the residual rows.
module lfit_chi_sum #(
  parameter int NCHI = 9,
  parameter int ACCW = 36,
  parameter int CHIW = 76
) (
  input  logic [NCHI*ACCW-1:0] comps,
  output logic [CHIW-1:0]      sum
);
  logic signed [2*ACCW-1:0] ext;
  logic [2*ACCW-1:0]        sq;

  always_comb begin
    sum = '0;
    ext = '0;
    sq  = '0;
    for (int k = 0; k < NCHI; k++) begin
      ext = signed'(comps[k*ACCW +: ACCW]);
      sq  = ext * ext;
      sum = sum + CHIW'(sq);
    end
  end
endmodule

// File: rtl/lfit_top.sv
`timescale 1ns/1ps
module lfit_top #(
  parameter int NCOORD = lfit_pkg::DEF_NCOORD,
  parameter int NPARAM = lfit_pkg::DEF_NPARAM,
  parameter int NSECT  = lfit_pkg::DEF_NSECT,
  parameter int XW     = lfit_pkg::DEF_XW,
  parameter int CW     = lfit_pkg::DEF_CW,
  localparam int NOUT  = NCOORD,
  localparam int NCHI  = NOUT - NPARAM,
  localparam int SW    = $clog2(NSECT),
  localparam int RIW   = $clog2(NOUT),
  localparam int RW    = (NCOORD + 1) * CW,
  localparam int ACCW  = lfit_pkg::acc_width(XW, CW, NCOORD),
  localparam int CHIW  = lfit_pkg::chi_width(ACCW, NCHI)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_we,
  input  logic [SW-1:0]          cfg_sector,
  input  logic [RIW-1:0]         cfg_row,
  input  logic [RW-1:0]          cfg_data,
  input  logic [CHIW-1:0]        chi_limit,
  input  logic                   in_valid,
  input  logic [SW-1:0]          in_sector,
  input  logic [NCOORD*XW-1:0]   in_coords,
  output logic                   out_valid,
  output logic [NPARAM*ACCW-1:0] out_params,
  output logic [CHIW-1:0]        out_chi2,
  output logic                   out_accept
);
  // Stage 1: constant lookup and coordinate capture
  logic [NCOORD*XW-1:0] s1_x;
  logic                 v1, v2, v3;
  logic [RW-1:0]        row_q [NOUT];
  logic signed [ACCW-1:0] acc [NOUT];

  logic [NPARAM*ACCW-1:0] par_vec;
  logic [NCHI*ACCW-1:0]   chi_vec;
  logic [CHIW-1:0]        chi_sum;

  always_ff @(posedge clk) begin
    s1_x <= in_coords;
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
    end else begin
      v1 <= in_valid;
      v2 <= v1;
      v3 <= v2;
    end
  end

  // Stages 1..3 per output row
  for (genvar r = 0; r < NOUT; r++) begin : g_row
    lfit_row_ram #(.DEPTH(NSECT), .W(RW), .AW(SW)) u_ram (
      .clk   (clk),
      .we    (cfg_we && (cfg_row == RIW'(r))),
      .waddr (cfg_sector),
      .wdata (cfg_data),
      .raddr (in_sector),
      .rdata (row_q[r])
    );

    lfit_mac_row #(.NCOORD(NCOORD), .XW(XW), .CW(CW), .ACCW(ACCW)) u_mac (
      .clk (clk),
      .row (row_q[r]),
      .x   (s1_x),
      .acc (acc[r])
    );

    if (r < NPARAM) begin : g_par
      assign par_vec[r*ACCW +: ACCW] = acc[r];
    end else begin : g_chi
      assign chi_vec[(r-NPARAM)*ACCW +: ACCW] = acc[r];
    end
  end

  lfit_chi_sum #(.NCHI(NCHI), .ACCW(ACCW), .CHIW(CHIW)) u_chi (
    .comps (chi_vec),
    .sum   (chi_sum)
  );

  // Stage 4: registered outputs, updated only for a valid candidate
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_params <= '0;
      out_chi2   <= '0;
      out_accept <= 1'b0;
    end else begin
      out_valid <= v3;
      if (v3) begin
        out_params <= par_vec;
        out_chi2   <= chi_sum;
        out_accept <= (chi_sum <= chi_limit);
      end
    end
  end
endmodule

// File: rtl/lfit_chk.sv
`timescale 1ns/1ps
module lfit_chk #(
  parameter int PW   = 180,
  parameter int CHIW = 76
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [CHIW-1:0] chi_limit,
  input logic            out_valid,
  input logic [PW-1:0]   out_params,
  input logic [CHIW-1:0] out_chi2,
  input logic            out_accept
);
  logic [2:0] cyc;

  always_ff @(posedge clk) begin
    if (rst) cyc <= '0;
    else if (cyc != 3'd7) cyc <= cyc + 3'd1;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    (cyc < 3'd4) |-> !out_valid);

  assert_fixed_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 3'd4) |-> (out_valid == $past(in_valid, 4)));

  assert_hold_outputs_R8: assert property (@(posedge clk) disable iff (rst)
    ((cyc >= 3'd1) && !out_valid) |-> ($stable(out_params) && $stable(out_chi2) && $stable(out_accept)));

  assert_accept_rule_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_accept == (out_chi2 <= $past(chi_limit))));
endmodule

bind lfit_top lfit_chk #(.PW(NPARAM*ACCW), .CHIW(CHIW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .chi_limit  (chi_limit),
  .out_valid  (out_valid),
  .out_params (out_params),
  .out_chi2   (out_chi2),
  .out_accept (out_accept)
);

// File: tb/sim_lfit_top.sv
`timescale 1ns/1ps
module sim_lfit_top;
  localparam int NCOORD = 14;
  localparam int NPARAM = 5;
  localparam int NSECT  = 16;
  localparam int XW     = 16;
  localparam int CW     = 16;
  localparam int NOUT   = NCOORD;
  localparam int SW     = 4;
  localparam int RIW    = 4;
  localparam int RW     = (NCOORD + 1) * CW;
  localparam int ACCW   = 36;
  localparam int CHIW   = 76;

  typedef struct packed {
    logic [3:0]         sec;
    logic [1:0]         mode;
    logic signed [15:0] base;
  } stim_t;

  // mode 0 ramp, 1 alternating sign, 2 single nonzero, 3 full-scale negative
  localparam int NV = 8;
  localparam stim_t TBL [NV] = '{
    '{4'd0,  2'd0,  16'sd100},
    '{4'd1,  2'd1,  16'sd250},
    '{4'd2,  2'd1,  16'sd250},
    '{4'd5,  2'd2,  16'sd5},
    '{4'd9,  2'd0, -16'sd400},
    '{4'd15, 2'd3,  16'sd0},
    '{4'd3,  2'd0,  16'sd7},
    '{4'd4,  2'd0,  16'sd7}
  };

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic                   cfg_we = 1'b0;
  logic [SW-1:0]          cfg_sector = '0;
  logic [RIW-1:0]         cfg_row = '0;
  logic [RW-1:0]          cfg_data = '0;
  logic [CHIW-1:0]        chi_limit = '0;
  logic                   in_valid = 1'b0;
  logic [SW-1:0]          in_sector = '0;
  logic [NCOORD*XW-1:0]   in_coords = '0;
  logic                   out_valid;
  logic [NPARAM*ACCW-1:0] out_params;
  logic [CHIW-1:0]        out_chi2;
  logic                   out_accept;

  lfit_top #(.NCOORD(NCOORD), .NPARAM(NPARAM), .NSECT(NSECT), .XW(XW), .CW(CW)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sector(cfg_sector), .cfg_row(cfg_row),
    .cfg_data(cfg_data), .chi_limit(chi_limit), .in_valid(in_valid), .in_sector(in_sector),
    .in_coords(in_coords), .out_valid(out_valid), .out_params(out_params),
    .out_chi2(out_chi2), .out_accept(out_accept)
  );

  always #2 clk = ~clk;

  logic signed [CW-1:0] coef_m [NSECT][NOUT][NCOORD];
  logic signed [CW-1:0] off_m  [NSECT][NOUT];
  logic signed [ACCW-1:0] last_p [NPARAM];
  logic [CHIW-1:0] last_c;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [CHIW-1:0] act, input logic [CHIW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void make_x(input stim_t t, output logic signed [XW-1:0] x [NCOORD]);
    int b;
    b = t.base;
    for (int j = 0; j < NCOORD; j++) begin
      case (t.mode)
        2'd0:    x[j] = XW'(b + 37 * j);
        2'd1:    x[j] = (j % 2 == 1) ? XW'(-b) : XW'(b + j);
        2'd2:    x[j] = (j == (b % NCOORD)) ? XW'(b) : '0;
        default: x[j] = 16'sh8000;
      endcase
    end
  endfunction

  function automatic logic signed [ACCW-1:0] ref_row(input int s, input int r,
                                                     input logic signed [XW-1:0] x [NCOORD]);
    logic signed [ACCW-1:0] acc, a, v;
    acc = off_m[s][r];
    for (int j = 0; j < NCOORD; j++) begin
      a = coef_m[s][r][j];
      v = x[j];
      acc = acc + a * v;
    end
    return acc;
  endfunction

  function automatic logic [CHIW-1:0] ref_chi(input int s, input logic signed [XW-1:0] x [NCOORD]);
    logic signed [CHIW-1:0] e;
    logic [CHIW-1:0] sum;
    sum = '0;
    for (int r = NPARAM; r < NOUT; r++) begin
      e = ref_row(s, r, x);
      sum = sum + CHIW'(e * e);
    end
    return sum;
  endfunction

  task automatic load_row(input int s, input int r);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_sector = SW'(s);
    cfg_row = RIW'(r);
    for (int j = 0; j < NCOORD; j++) cfg_data[j*CW +: CW] = coef_m[s][r][j];
    cfg_data[NCOORD*CW +: CW] = off_m[s][r];
  endtask

  // Streams table entries [first, first+count), optionally with a gap after each.
  task automatic run_stream(input int first, input int count, input bit gaps,
                            input logic [CHIW-1:0] thr);
    logic                   ev [64];
    logic signed [ACCW-1:0] ep [64][NPARAM];
    logic [CHIW-1:0]        ec [64];
    logic signed [XW-1:0]   x  [NCOORD];
    int nxt;
    int ncyc;
    nxt = first;
    ncyc = (gaps ? 2 * count : count) + 4;
    @(negedge clk);
    chi_limit = thr;
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      if (c >= 4) begin
        int k;
        k = c - 4;
        chk(out_valid == ev[k], "R2", "out_valid timing", CHIW'(out_valid), CHIW'(ev[k]));
        if (ev[k]) begin
          for (int i = 0; i < NPARAM; i++)
            chk(signed'(out_params[i*ACCW +: ACCW]) == ep[k][i], "R3", $sformatf("param %0d", i),
                CHIW'(out_params[i*ACCW +: ACCW]), CHIW'(ep[k][i]));
          chk(out_chi2 == ec[k], "R4", "chi-square", out_chi2, ec[k]);
          chk(out_accept == (ec[k] <= thr), "R6", "accept flag",
              CHIW'(out_accept), CHIW'(ec[k] <= thr));
          for (int i = 0; i < NPARAM; i++) last_p[i] = ep[k][i];
          last_c = ec[k];
        end
      end
      if (nxt < first + count && !(gaps && (c % 2 == 1))) begin
        make_x(TBL[nxt], x);
        in_valid = 1'b1;
        in_sector = TBL[nxt].sec;
        for (int j = 0; j < NCOORD; j++) in_coords[j*XW +: XW] = x[j];
        ev[c] = 1'b1;
        for (int i = 0; i < NPARAM; i++) ep[c][i] = ref_row(int'(TBL[nxt].sec), i, x);
        ec[c] = ref_chi(int'(TBL[nxt].sec), x);
        nxt++;
      end else begin
        in_valid = 1'b0;
        in_sector = SW'(c);
        in_coords = {NCOORD{XW'(c * 4099)}};
        ev[c] = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic signed [XW-1:0] x0 [NCOORD];
    logic [CHIW-1:0] e0;

    // R1: reset ignores in_valid and clears outputs
    in_valid = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "valid in reset", CHIW'(out_valid), '0);
    chk(out_chi2 == '0, "R1", "chi2 in reset", out_chi2, '0);
    chk(out_accept == 1'b0, "R1", "accept in reset", CHIW'(out_accept), '0);
    rst = 1'b0;
    in_valid = 1'b0;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R1", "valid after reset", CHIW'(out_valid), '0);
    end

    // R7: constant table load (row order: params then residual rows)
    for (int s = 0; s < NSECT; s++)
      for (int r = 0; r < NOUT; r++) begin
        for (int j = 0; j < NCOORD; j++)
          coef_m[s][r][j] = (s == 15) ? 16'sh8000 : CW'(((s * 13 + r * 7 + j * 5) % 41) - 20);
        off_m[s][r] = (s == 15) ? 16'sh8000 : CW'(s * 64 - r * 9);
      end
    for (int s = 0; s < NSECT; s++)
      for (int r = 0; r < NOUT; r++) load_row(s, r);
    @(negedge clk);
    cfg_we = 1'b0;

    // R3 R4 R5 R9: whole table back to back, then with gaps (R2)
    run_stream(0, NV, 1'b0, CHIW'(1) << 37);
    run_stream(0, NV, 1'b1, CHIW'(1) << 37);

    // R6: threshold equal to chi-square accepts, one below rejects
    make_x(TBL[0], x0);
    e0 = ref_chi(0, x0);
    run_stream(0, 1, 1'b0, e0);
    chk(out_accept == 1'b1, "R6", "accept at equal limit", CHIW'(out_accept), 1);
    run_stream(0, 1, 1'b0, e0 - 1);
    chk(out_accept == 1'b0, "R6", "reject one below", CHIW'(out_accept), 0);

    // R8: outputs hold while no candidate emerges
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      in_sector = SW'(c + 3);
      in_coords = {NCOORD{XW'(c * 777 + 1)}};
      chk(out_chi2 == last_c, "R8", "chi2 held", out_chi2, last_c);
      for (int i = 0; i < NPARAM; i++)
        chk(signed'(out_params[i*ACCW +: ACCW]) == last_p[i], "R8", "param held",
            CHIW'(out_params[i*ACCW +: ACCW]), CHIW'(last_p[i]));
    end

    // R7: rewrite two rows of sector 3, sector 4 must be untouched
    for (int j = 0; j < NCOORD; j++) begin
      coef_m[3][0][j] = CW'(j * 3 - 11);
      coef_m[3][7][j] = CW'(19 - j * 2);
    end
    off_m[3][0] = 16'sd1234;
    off_m[3][7] = -16'sd321;
    load_row(3, 0);
    load_row(3, 7);
    @(negedge clk);
    cfg_we = 1'b0;
    run_stream(6, 2, 1'b0, CHIW'(1) << 37);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule